// File: doc/BRIEF.md
# HDLC Abort Detector with Hunt Control

This block sits beside the bit-level deframer of an HDLC/SDLC receiver. It watches the recovered serial bits and recognises the abort pattern, a run of seven consecutive 1 bits. When the pattern appears, it raises a live abort status and forces the receiver into hunt mode. If the receiver was inside a frame, it also tells the deframer to throw away the character it was assembling. The receive FIFO is left alone.

The abort status is not latched. It falls on the next valid 0 bit, whether that 0 ends the abort or is the first bit of a flag. Hunt mode outlives the abort and ends only when the external flag detector reports a flag. An abort is treated the same way inside and outside a frame. An idle line of 1s after a closing flag therefore produces an abort about seven bit times after the frame ends, and that abort lasts until the next flag. Every change of either status bit can raise a one-cycle interrupt event, gated by an enable input.

Top module: `hdlc_abort_hunt`

## Requirements
- R1: While and right after reset, `abort_sts` is 0, `hunt_sts` is 1, and `irq_pulse` and `drop_char` are 0.
- R2: The seventh consecutive valid 1 bit sets `abort_sts` in the cycle after its strobe. Six valid 1s followed by a valid 0 do not set it.
- R3: `rx_bit` is ignored when `rx_bit_vld` is 0. Such cycles neither extend nor break a run of 1s.
- R4: The cycle that sets `abort_sts` also sets `hunt_sts` to 1.
- R5: A valid 0 bit clears `abort_sts` in the following cycle.
- R6: `hunt_sts` stays 1 after the abort clears, and falls in the cycle after a `flag_det` pulse. A `flag_det` arriving while the abort is active, or in the same cycle as a detection, is ignored.
- R7: The run counter saturates. An unbroken run of 1s longer than seven gives exactly one detection, and `abort_sts` stays 1 throughout the run.
- R8: `irq_pulse` is high for one cycle, in the same cycle as the change, each time `abort_sts` or `hunt_sts` changes. It gives a single pulse when both change together, and it is never high without a status change.
- R9: With `irq_en` at 0 during the cycle that causes a change, the status bits still update but `irq_pulse` stays 0.
- R10: `drop_char` pulses for one cycle, together with the rise of `abort_sts`, only when `in_frame` was 1 at detection. Out-of-frame aborts update status without this pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_bit | input | 1 | Received data bit after zero-deletion input stage |
| rx_bit_vld | input | 1 | Strobe marking `rx_bit` as a new bit |
| flag_det | input | 1 | One-cycle pulse from the flag detector |
| in_frame | input | 1 | Deframer is between opening and closing flags |
| irq_en | input | 1 | Enables interrupt events for status changes |
| abort_sts | output | 1 | Live abort status |
| hunt_sts | output | 1 | Receiver is in hunt mode |
| drop_char | output | 1 | One-cycle pulse: discard the partial character |
| irq_pulse | output | 1 | One-cycle interrupt event |

## Verification
The checker watches every cycle for the following:
- each rise of the abort status follows a valid 1 bit, and each fall follows a valid 0 bit;
- hunt is 1 whenever abort is 1, and hunt only falls after a flag pulse;
- an interrupt event appears for every abort change while enabled, never without a status change, and never while disabled;
- a drop pulse only comes with an abort rise inside a frame.

Only the scenarios in the bench can show the exact run length that triggers, which needs a six-ones near miss and gaps in the strobe. The same holds for the absence of a second detection in a long run of 1s, and for the priority when a flag and a detection coincide.

// File: rtl/abd_pkg.sv
package abd_pkg;
   typedef struct packed {
      logic abort;
      logic hunt;
   } abd_sts_t;

   function automatic int unsigned run_width(input int unsigned ones);
      return $clog2(ones + 1);
   endfunction
endpackage

// File: rtl/abd_ones_cnt.sv
module abd_ones_cnt #(
   parameter int unsigned ABORT_ONES = 7,
   parameter int unsigned CNT_W      = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic bit_vld,
   input  logic bit_val,
   output logic hit
);
   localparam logic [CNT_W-1:0] RUN_LAST = CNT_W'(ABORT_ONES - 1);
   localparam logic [CNT_W-1:0] RUN_SAT  = CNT_W'(ABORT_ONES);

   logic [CNT_W-1:0] run_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         run_q <= '0;
      end else if (bit_vld) begin
         if (!bit_val)
            run_q <= '0;
         else if (run_q != RUN_SAT)
            run_q <= run_q + 1'b1;
      end
   end

   // fires once per run: after saturation run_q never equals RUN_LAST again
   assign hit = bit_vld && bit_val && (run_q == RUN_LAST);
endmodule

// File: rtl/abd_status.sv
module abd_status
   import abd_pkg::*;
#(
   parameter bit HUNT_RST = 1'b1
) (
   input  logic     clk,
   input  logic     rst_n,
   input  logic     hit,
   input  logic     zero_bit,
   input  logic     flag_det,
   output abd_sts_t sts_q,
   output abd_sts_t sts_d
);
   always_comb begin
      sts_d = sts_q;
      if (hit)
         sts_d.abort = 1'b1;
      else if (zero_bit)
         sts_d.abort = 1'b0;
      if (hit)
         sts_d.hunt = 1'b1;
      else if (flag_det && !sts_d.abort)
         sts_d.hunt = 1'b0;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sts_q.abort <= 1'b0;
         sts_q.hunt  <= HUNT_RST;
      end else begin
         sts_q <= sts_d;
      end
   end
endmodule

// File: rtl/abd_event.sv
module abd_event
   import abd_pkg::*;
#(
   parameter bit HUNT_IRQ = 1'b1
) (
   input  logic     clk,
   input  logic     rst_n,
   input  abd_sts_t sts_q,
   input  abd_sts_t sts_d,
   input  logic     hit,
   input  logic     in_frame,
   input  logic     irq_en,
   output logic     irq_pulse,
   output logic     drop_char
);
   logic sts_chg;

   generate
      if (HUNT_IRQ) begin : g_both_src
         assign sts_chg = (sts_d != sts_q);
      end else begin : g_abort_src
         assign sts_chg = (sts_d.abort != sts_q.abort);
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         irq_pulse <= 1'b0;
         drop_char <= 1'b0;
      end else begin
         irq_pulse <= irq_en && sts_chg;
         drop_char <= hit && in_frame;
      end
   end
endmodule

// File: rtl/hdlc_abort_hunt.sv
module hdlc_abort_hunt
   import abd_pkg::*;
#(
   parameter int unsigned ABORT_ONES = 7,
   parameter bit          HUNT_IRQ   = 1'b1,
   parameter bit          HUNT_RST   = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic rx_bit,
   input  logic rx_bit_vld,
   input  logic flag_det,
   input  logic in_frame,
   input  logic irq_en,
   output logic abort_sts,
   output logic hunt_sts,
   output logic drop_char,
   output logic irq_pulse
);
   localparam int unsigned CNT_W = run_width(ABORT_ONES);

   generate
      if (ABORT_ONES < 2 || ABORT_ONES > 255) begin : g_bad_ones
         $error("hdlc_abort_hunt: ABORT_ONES must lie in 2..255");
      end
   endgenerate

   logic     hit;
   abd_sts_t sts_q;
   abd_sts_t sts_d;

   abd_ones_cnt #(.ABORT_ONES(ABORT_ONES), .CNT_W(CNT_W)) u_cnt (
      .clk    (clk),
      .rst_n  (rst_n),
      .bit_vld(rx_bit_vld),
      .bit_val(rx_bit),
      .hit    (hit)
   );

   abd_status #(.HUNT_RST(HUNT_RST)) u_sts (
      .clk     (clk),
      .rst_n   (rst_n),
      .hit     (hit),
      .zero_bit(rx_bit_vld && !rx_bit),
      .flag_det(flag_det),
      .sts_q   (sts_q),
      .sts_d   (sts_d)
   );

   abd_event #(.HUNT_IRQ(HUNT_IRQ)) u_evt (
      .clk      (clk),
      .rst_n    (rst_n),
      .sts_q    (sts_q),
      .sts_d    (sts_d),
      .hit      (hit),
      .in_frame (in_frame),
      .irq_en   (irq_en),
      .irq_pulse(irq_pulse),
      .drop_char(drop_char)
   );

   assign abort_sts = sts_q.abort;
   assign hunt_sts  = sts_q.hunt;
endmodule

// File: rtl/abd_checker.sv
module abd_checker (
   input logic clk,
   input logic rst_n,
   input logic rx_bit,
   input logic rx_bit_vld,
   input logic flag_det,
   input logic in_frame,
   input logic irq_en,
   input logic abort_sts,
   input logic hunt_sts,
   input logic drop_char,
   input logic irq_pulse
);
   p_abort_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(abort_sts) |-> $past(rx_bit_vld && rx_bit));

   p_abort_fall_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(abort_sts) |-> $past(rx_bit_vld && !rx_bit));

   p_hunt_covers_abort_r4: assert property (@(posedge clk) disable iff (!rst_n)
      abort_sts |-> hunt_sts);

   p_hunt_leave_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(hunt_sts) |-> $past(flag_det));

   p_irq_on_abort_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ((abort_sts != $past(abort_sts)) && $past(irq_en)) |-> irq_pulse);

   p_irq_has_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
      irq_pulse |-> ((abort_sts != $past(abort_sts)) || (hunt_sts != $past(hunt_sts))));

   p_irq_masked_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(irq_en) |-> !irq_pulse);

   p_drop_in_frame_r10: assert property (@(posedge clk) disable iff (!rst_n)
      drop_char |-> ($rose(abort_sts) && $past(in_frame)));
endmodule

bind hdlc_abort_hunt abd_checker u_abd_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .rx_bit    (rx_bit),
   .rx_bit_vld(rx_bit_vld),
   .flag_det  (flag_det),
   .in_frame  (in_frame),
   .irq_en    (irq_en),
   .abort_sts (abort_sts),
   .hunt_sts  (hunt_sts),
   .drop_char (drop_char),
   .irq_pulse (irq_pulse)
);

// File: tb/test_hdlc_abort_hunt.sv
module test_hdlc_abort_hunt;
   localparam int ONES = 7;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic rx_bit = 1'b0, rx_bit_vld = 1'b0, flag_det = 1'b0, in_frame = 1'b0, irq_en = 1'b0;
   logic abort_sts, hunt_sts, drop_char, irq_pulse;

   always #2 clk = ~clk;

   hdlc_abort_hunt #(.ABORT_ONES(ONES)) i_hdlc_abort_hunt (
      .clk(clk), .rst_n(rst_n), .rx_bit(rx_bit), .rx_bit_vld(rx_bit_vld),
      .flag_det(flag_det), .in_frame(in_frame), .irq_en(irq_en),
      .abort_sts(abort_sts), .hunt_sts(hunt_sts), .drop_char(drop_char),
      .irq_pulse(irq_pulse)
   );

   typedef struct {
      int    due;
      logic  a, h, d, i;
      string tag;
   } exp_t;

   exp_t sb[$];
   int   cyc = 0;
   int   n_chk = 0, n_fail = 0;
   bit   done = 0;

   // bench model state, built from the requirements
   int   m_run = 0;
   logic m_abort = 1'b0, m_hunt = 1'b1;

   always @(posedge clk) cyc <= cyc + 1;

   // monitor: compare every expected item in its due cycle
   always @(negedge clk) begin
      while (sb.size() > 0 && sb[0].due == cyc) begin
         exp_t e;
         e = sb.pop_front();
         n_chk++;
         if ({abort_sts, hunt_sts, drop_char, irq_pulse} !== {e.a, e.h, e.d, e.i}) begin
            n_fail++;
            $display("FAIL %s cyc %0d: got abort=%0b hunt=%0b drop=%0b irq=%0b expected abort=%0b hunt=%0b drop=%0b irq=%0b",
                     e.tag, cyc, abort_sts, hunt_sts, drop_char, irq_pulse, e.a, e.h, e.d, e.i);
         end
      end
   end

   // driver: apply one cycle of inputs and push the expected result
   task automatic step(input logic b, input logic v, input logic f,
                       input logic inf, input logic en, input string tag);
      logic hit, na, nh;
      exp_t e;
      @(negedge clk);
      rx_bit = b; rx_bit_vld = v; flag_det = f; in_frame = inf; irq_en = en;
      hit = v && b && (m_run == ONES - 1);
      if (v) m_run = b ? ((m_run < ONES) ? m_run + 1 : m_run) : 0;
      na = hit ? 1'b1 : (v && !b) ? 1'b0 : m_abort;
      nh = hit ? 1'b1 : (f && !na) ? 1'b0 : m_hunt;
      e.due = cyc + 1;
      e.a = na; e.h = nh;
      e.d = hit && inf;
      e.i = en && ((na != m_abort) || (nh != m_hunt));
      e.tag = tag;
      m_abort = na; m_hunt = nh;
      sb.push_back(e);
   endtask

   task automatic ones(input int n, input logic inf, input logic en, input string tag);
      for (int k = 0; k < n; k++) step(1'b1, 1'b1, 1'b0, inf, en, tag);
   endtask

   task automatic report;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: got running expected finished");
         report();
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset values
      n_chk++;
      if ({abort_sts, hunt_sts, drop_char, irq_pulse} !== 4'b0100) begin
         n_fail++;
         $display("FAIL R1 reset: got %b expected 0100", {abort_sts, hunt_sts, drop_char, irq_pulse});
      end
      rst_n = 1'b1;
      n_chk++;
      if ({abort_sts, hunt_sts, drop_char, irq_pulse} !== 4'b0100) begin
         n_fail++;
         $display("FAIL R1 after release: got %b expected 0100", {abort_sts, hunt_sts, drop_char, irq_pulse});
      end

      // R6/R8: flag leaves hunt, interrupt on the change
      step(1'b0, 1'b0, 1'b1, 1'b0, 1'b1, "R6 flag leaves hunt / R8 irq");
      step(1'b0, 1'b1, 1'b0, 1'b1, 1'b1, "R8 quiet");
      // R2: six ones then a zero, no abort
      ones(6, 1'b1, 1'b1, "R2 six ones");
      step(1'b0, 1'b1, 1'b0, 1'b1, 1'b1, "R2 near miss");
      // R3: gaps in strobe with rx_bit low do not break the run
      ones(3, 1'b1, 1'b1, "R3 run part");
      step(1'b0, 1'b0, 1'b0, 1'b1, 1'b1, "R3 invalid zero");
      step(1'b0, 1'b0, 1'b0, 1'b1, 1'b1, "R3 invalid zero");
      ones(3, 1'b1, 1'b1, "R3 run part");
      step(1'b1, 1'b0, 1'b0, 1'b1, 1'b1, "R3 invalid one");
      // R2/R4/R10/R8: seventh valid one in frame
      ones(1, 1'b1, 1'b1, "R2 R4 R10 R8 seventh one");
      // R7: long run, no retrigger
      ones(12, 1'b1, 1'b1, "R7 saturation");
      // R6: flag while abort active ignored
      step(1'b1, 1'b0, 1'b1, 1'b0, 1'b1, "R6 flag during abort");
      // R5: zero clears abort, hunt held
      step(1'b0, 1'b1, 1'b0, 1'b0, 1'b1, "R5 zero clears / R6 hunt held");
      ones(2, 1'b0, 1'b1, "R6 hunt held");
      step(1'b0, 1'b1, 1'b1, 1'b0, 1'b1, "R6 flag leaves hunt");
      // R9/R10: out of frame, interrupts disabled
      ones(7, 1'b0, 1'b0, "R9 R10 masked out-of-frame abort");
      step(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, "R9 R5 masked clear");
      step(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, "R9 masked hunt exit");
      // R6/R8: detection and flag in the same cycle
      ones(6, 1'b1, 1'b1, "R6 pre-run");
      step(1'b1, 1'b1, 1'b1, 1'b1, 1'b1, "R6 R8 hit beats flag");
      step(1'b0, 1'b1, 1'b0, 1'b1, 1'b1, "R5 clear");
      // idle line after end of frame gives abort after seven bits
      step(1'b0, 1'b1, 1'b1, 1'b0, 1'b1, "R6 closing flag");
      ones(9, 1'b0, 1'b1, "R2 R10 idle mark abort");
      step(1'b0, 1'b1, 1'b0, 1'b0, 1'b1, "R5 next flag zero");
      step(1'b0, 1'b0, 1'b0, 1'b0, 1'b1, "R8 idle");
      repeat (3) @(negedge clk);
      n_chk++;
      if (sb.size() != 0) begin
         n_fail++;
         $display("FAIL R8 scoreboard drain: got %0d expected 0", sb.size());
      end
      done = 1;
      report();
      $finish;
   end
endmodule